// File: doc/BRIEF.md
# CRC-32 Barrett Reduction Unit

This block turns a 64-bit polynomial remainder into its final 32-bit CRC-32 value. It does not divide bit by bit. It uses a precomputed quotient constant and two carry-less multiplications. The upper half of the input is multiplied by mu = 0x104D101DF, which is floor(x^64 / P(x)). The upper half of that product is then multiplied by the generator P(x) = 0x104C11DB7. XORing the low word of the second product with the low word of the input gives R(x) mod P(x).

The unit sits at the end of a folding datapath. Folding, bit reflection and final inversion are handled upstream or downstream. The unit has two multiplier stages, each followed by a register, so the result appears a fixed two cycles after its input. A new value can be accepted on every clock.

Top module: `crc32_barrett_reduce`

## Requirements
- R1: While reset is high and on the cycle after it is released, `res_vld` is 0 and `res_crc` is 0.
- R2: `res_vld` is high exactly two clock edges after an edge at which `rem_vld` was high, and low otherwise.
- R3: When `res_vld` is high, `res_crc` equals the 64-bit input taken two edges earlier reduced modulo P(x) = 0x104C11DB7. The input is read as a polynomial whose bit i is the coefficient of x^i.
- R4: An input of zero produces a result of zero.
- R5: An input whose upper 32 bits are all zero produces its own lower 32 bits unchanged, because its degree is already below 32.
- R6: The input x^32 (0x0000_0001_0000_0000) produces 0x04C11DB7.
- R7: Inputs presented on consecutive clocks produce results on consecutive clocks, in the same order, with no gaps.
- R8: While `rem_vld` is low, `rem_data` is ignored. `res_crc` keeps the last result and `res_vld` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rem_vld | input | 1 | Marks `rem_data` as a new value to reduce |
| rem_data | input | 64 | Remainder polynomial R(x), bit i is the coefficient of x^i |
| res_vld | output | 1 | Registered strobe for a new result |
| res_crc | output | 32 | Registered CRC, R(x) mod P(x) |

## Verification
The assertions assume that `rem_vld` is a clean 0 or 1 on every sampled edge after reset. They also assume that `rem_data` is known whenever `rem_vld` is high. Those two facts make the two-cycle past looks for zero and low-word-only inputs meaningful. The stimulus drives both inputs on the falling edge only and never leaves them undefined. The idle test deliberately scrambles `rem_data` while `rem_vld` is low, because that is the situation the hold rule covers.

// File: rtl/crc_barrett_pkg.sv
package crc_barrett_pkg;
  localparam int          CRC32_W    = 32;
  // Generator, including the x^32 term
  localparam logic [32:0] CRC32_POLY = 33'h104C11DB7;
  // floor(x^64 / P(x))
  localparam logic [32:0] CRC32_MU   = 33'h104D101DF;
endpackage

// File: rtl/clmul_slice.sv
// Carry-less (GF(2)) product of a and b, giving only bits [OUT_LO +: OUT_W].
module clmul_slice #(
  parameter int A_W    = 32,
  parameter int B_W    = 33,
  parameter int OUT_LO = 0,
  parameter int OUT_W  = 32
) (
  input  logic [A_W-1:0]   a,
  input  logic [B_W-1:0]   b,
  output logic [OUT_W-1:0] p
);
  genvar j;
  generate
    for (j = 0; j < OUT_W; j++) begin : g_bit
      localparam int K = OUT_LO + j;
      always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < A_W; i++) begin
          if ((K - i) >= 0 && (K - i) < B_W)
            acc = acc ^ (a[i] & b[K - i]);
        end
        p[j] = acc;
      end
    end
  endgenerate
endmodule

// File: rtl/barrett_quot_stage.sv
// Stage 1: quotient estimate = upper half of clmul(R_hi, mu).
module barrett_quot_stage #(
  parameter int               CRC_W = 32,
  parameter logic [CRC_W:0]   MU    = 33'h104D101DF,
  localparam int              IN_W  = 2 * CRC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_rem,
  output logic             q_vld,
  output logic [CRC_W-1:0] q_val,
  output logic [CRC_W-1:0] q_rlo
);
  logic [CRC_W-1:0] quot_c;

  clmul_slice #(
    .A_W(CRC_W), .B_W(CRC_W + 1), .OUT_LO(CRC_W), .OUT_W(CRC_W)
  ) u_mul_mu (
    .a(in_rem[IN_W-1:CRC_W]),
    .b(MU),
    .p(quot_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_val <= '0;
      q_rlo <= '0;
    end else begin
      q_vld <= in_vld;
      if (in_vld) begin
        q_val <= quot_c;
        q_rlo <= in_rem[CRC_W-1:0];
      end
    end
  end

  // R2
  stage1_vld_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> q_vld);
endmodule

// File: rtl/barrett_fold_stage.sv
// Stage 2: remainder = R_lo XOR low half of clmul(quotient, P).
module barrett_fold_stage #(
  parameter int             CRC_W = 32,
  parameter logic [CRC_W:0] POLY  = 33'h104C11DB7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_vld,
  input  logic [CRC_W-1:0] q_val,
  input  logic [CRC_W-1:0] q_rlo,
  output logic             o_vld,
  output logic [CRC_W-1:0] o_crc
);
  logic [CRC_W-1:0] t2_lo;

  clmul_slice #(
    .A_W(CRC_W), .B_W(CRC_W + 1), .OUT_LO(0), .OUT_W(CRC_W)
  ) u_mul_poly (
    .a(q_val),
    .b(POLY),
    .p(t2_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= 1'b0;
      o_crc <= '0;
    end else begin
      o_vld <= q_vld;
      if (q_vld) o_crc <= q_rlo ^ t2_lo;
    end
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !q_vld |=> ($stable(o_crc) && !o_vld));
endmodule

// File: rtl/crc32_barrett_reduce.sv
module crc32_barrett_reduce
  import crc_barrett_pkg::*;
#(
  parameter int             CRC_W = CRC32_W,
  parameter logic [CRC_W:0] POLY  = CRC32_POLY,
  parameter logic [CRC_W:0] MU    = CRC32_MU,
  localparam int            IN_W  = 2 * CRC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rem_vld,
  input  logic [IN_W-1:0]  rem_data,
  output logic             res_vld,
  output logic [CRC_W-1:0] res_crc
);
  logic             s1_vld;
  logic [CRC_W-1:0] s1_quot;
  logic [CRC_W-1:0] s1_rlo;

  barrett_quot_stage #(.CRC_W(CRC_W), .MU(MU)) u_quot (
    .clk(clk), .rst(rst),
    .in_vld(rem_vld), .in_rem(rem_data),
    .q_vld(s1_vld), .q_val(s1_quot), .q_rlo(s1_rlo)
  );

  barrett_fold_stage #(.CRC_W(CRC_W), .POLY(POLY)) u_fold (
    .clk(clk), .rst(rst),
    .q_vld(s1_vld), .q_val(s1_quot), .q_rlo(s1_rlo),
    .o_vld(res_vld), .o_crc(res_crc)
  );

  // R2
  res_vld_origin_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(rem_vld, 2));

  // R4
  zero_in_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(rem_data, 2) == '0) |-> res_crc == '0);

  // R5
  low_word_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && $past(rem_data[IN_W-1:CRC_W], 2) == '0)
      |-> res_crc == $past(rem_data[CRC_W-1:0], 2));
endmodule

// File: tb/crc32_barrett_reduce_tb.sv
module crc32_barrett_reduce_tb;
  localparam logic [32:0] GEN = 33'h104C11DB7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rem_vld = 1'b0;
  logic [63:0] rem_data = '0;
  logic        res_vld;
  logic [31:0] res_crc;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #5 clk = ~clk;

  crc32_barrett_reduce u_dut (
    .clk(clk), .rst(rst), .rem_vld(rem_vld), .rem_data(rem_data),
    .res_vld(res_vld), .res_crc(res_crc)
  );

  function automatic logic [31:0] ref_mod(input logic [63:0] r);
    logic [63:0] w = r;
    for (int i = 63; i >= 32; i--)
      if (w[i]) w = w ^ ({31'b0, GEN} << (i - 32));
    return w[31:0];
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One value through the pipe: drive, let two edges pass, then compare.
  task automatic run_one(input string req, input logic [63:0] r, input logic [31:0] exp);
    @(negedge clk); rem_vld = 1'b1; rem_data = r;
    @(negedge clk); rem_vld = 1'b0; rem_data = ~r;
    check({req, " early_vld"}, {63'b0, res_vld}, 64'd0);
    @(negedge clk);
    check({req, " vld"}, {63'b0, res_vld}, 64'd1);
    check(req, {32'b0, res_crc}, {32'b0, exp});
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 vld_in_reset", {63'b0, res_vld}, 64'd0);
    check("R1 crc_in_reset", {32'b0, res_crc}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 vld_after", {63'b0, res_vld}, 64'd0);
    check("R1 crc_after", {32'b0, res_crc}, 64'd0);
  endtask

  task automatic t_zero();
    run_one("R4 zero", 64'h1234_5678_9ABC_DEF0, ref_mod(64'h1234_5678_9ABC_DEF0));
    run_one("R4 zero", 64'd0, 32'd0);
  endtask

  task automatic t_low_only();
    run_one("R5 low_only", 64'h0000_0000_DEAD_BEEF, 32'hDEAD_BEEF);
    run_one("R5 low_only", 64'h0000_0000_FFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_x32();
    run_one("R6 x32", 64'h0000_0001_0000_0000, 32'h04C1_1DB7);
  endtask

  task automatic t_values();
    run_one("R3 all_ones", 64'hFFFF_FFFF_FFFF_FFFF, ref_mod(64'hFFFF_FFFF_FFFF_FFFF));
    run_one("R3 top_bit", 64'h8000_0000_0000_0000, ref_mod(64'h8000_0000_0000_0000));
    for (int k = 0; k < 20; k++) begin
      seed = next_rand(seed);
      run_one("R3 rand", seed, ref_mod(seed));
    end
  endtask

  task automatic t_burst();
    logic [63:0] vals [16];
    for (int k = 0; k < 16; k++) begin
      seed = next_rand(seed);
      vals[k] = (k == 5) ? 64'd0 : seed;
    end
    for (int j = 0; j < 18; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R7 burst_vld", {63'b0, res_vld}, 64'd1);
        check("R7 burst_crc", {32'b0, res_crc}, {32'b0, ref_mod(vals[j-2])});
      end
      if (j < 16) begin
        rem_vld = 1'b1; rem_data = vals[j];
      end else begin
        rem_vld = 1'b0; rem_data = '0;
      end
    end
    @(negedge clk);
    check("R7 burst_end", {63'b0, res_vld}, 64'd0);
  endtask

  task automatic t_idle_hold();
    logic [31:0] held;
    run_one("R8 prime", 64'hCAFE_F00D_0BAD_BEEF, ref_mod(64'hCAFE_F00D_0BAD_BEEF));
    held = res_crc;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      seed = next_rand(seed);
      rem_vld = 1'b0; rem_data = seed;
      check("R8 idle_vld", {63'b0, res_vld}, 64'd0);
      check("R8 idle_crc", {32'b0, res_crc}, {32'b0, held});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_zero();
    t_low_only();
    t_x32();
    t_values();
    t_burst();
    t_idle_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule